// File: doc/BRIEF.md
# Hot-Swap Sequencing Controller

This block sequences the power-up of a board behind an external pass switch. It decides when the switch may turn on, how long an overcurrent may last before the attempt is aborted, and what happens after an abort. A capacitor-based analog timer is replaced here by one shared up/down counter. That counter serves several jobs in turn: a two-phase power-on delay, fault-duration timing, and an automatic-retry cool-down.

The analog parts are out of scope and reach the block as digital flags. These are the gate regulator, the comparators and the supply lockout detector. There is a supply-good flag, which already has hysteresis applied. There are two overcurrent flags: one that starts fault timing and one for a hard short. The block drives a gate-enable request and a strong gate pull-down request. It also provides a fault flag, a one-cycle fault-entry pulse for the alert logic, a ready flag and a timing-in-progress flag.

A mode strap selects what happens after a fault. In latch mode the block waits for a fresh enable. In retry mode it restarts by itself after a cool-down that is about 25 times as long as the fault window. The timer rates and thresholds are parameters.

Top module: `hotswap_seq`

## Requirements
- R1: While `supply_ok_i` is low, the block is held in its lockout state from the next clock edge on, with the timer cleared to zero. In that state `gate_on_o`, `ready_o` and `fault_o` are low.
- R2: After the supply becomes good, the timer first rises by RATE_INIT_UP (1) per cycle until it reaches TMR_HI (600). It then falls by RATE_FAST_DN (20) per cycle until it is at or below TMR_LO (100). Only then does `ready_o` rise.
- R3: `gate_on_o` stays low until `ready_o` is high and the filtered enable is high. From the idle state, a high filtered enable with `sw_off_i` low starts the hot-swap: the gate is on from the next edge.
- R4: While on, the timer rises by RATE_FAULT_UP (12) per cycle only while `oc_timed_i` is high, and `timing_o` is high. If the flag drops before the timer reaches TMR_HI, the timer falls at the fast rate and the gate stays fully on.
- R5: If `oc_timed_i` is still high when the timer is at TMR_HI, a fault is entered at the next edge. In the fault state `gate_on_o` is low and `gate_fast_pd_o` and `fault_o` are high.
- R6: With `retry_mode_i` low, a fault latches: the gate stays off, whatever the overcurrent flags do, until the filtered enable has gone low. A later high enable restarts the hot-swap.
- R7: With `retry_mode_i` high, the timer falls after a fault by RETRY_NUM/RETRY_DEN (2/5) of a unit per cycle. It drops one unit each time an accumulator crosses the denominator. When the timer is at or below TMR_LO, the hot-swap restarts at the next edge.
- R8: While the gate is on, `oc_fast_i` high forces `gate_fast_pd_o` high and `gate_on_o` low in the same cycle, with no involvement of the timer or the state.
- R9: A filtered enable that is low, or `sw_off_i` high, turns the gate off from the next edge and discharges the timer at the fast rate.
- R10: A high `en_i` is seen as enabled one edge later. A low `en_i` takes effect only after EN_FILT_CYC (375) consecutive low samples, so a shorter low pulse has no effect on the gate.
- R11: `fault_pulse_o` is high for exactly the first cycle of each entry into the fault state, including each repeated entry in retry mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply above lockout threshold (hysteresis applied upstream) |
| en_i | input | 1 | Hot-swap enable pin, active high |
| sw_off_i | input | 1 | Software turn-off request |
| retry_mode_i | input | 1 | 1 = automatic retry after fault, 0 = latch off |
| oc_timed_i | input | 1 | Overcurrent above the fault-timing threshold |
| oc_fast_i | input | 1 | Overcurrent above the fast-trip threshold |
| gate_on_o | output | 1 | Request to drive the pass switch gate on |
| gate_fast_pd_o | output | 1 | Request for the strong gate pull-down |
| fault_o | output | 1 | Fault state active (latched or cooling) |
| fault_pulse_o | output | 1 | One-cycle pulse on each fault entry |
| ready_o | output | 1 | Power-on delay complete |
| timing_o | output | 1 | Overcurrent fault timing in progress |

## Verification
State-driven outputs (`gate_on_o`, `ready_o`, `fault_o`, `fault_pulse_o`) change one edge after the input or timer value that causes them. The exception is the enable release, which is due one edge after the 375th consecutive low sample. The fast-trip and timing flags combine the current state with the present overcurrent inputs, so they are due in the same cycle. The reference model advances at each rising edge from the inputs held since the previous falling edge. Every output is compared at the falling edge, and inputs change only after that comparison. As a result, the power-on delay, the 50-cycle fault window and the 1250-cycle cool-down are each checked at their exact cycle.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    ST_LOCK, ST_INIT_UP, ST_INIT_DN, ST_IDLE, ST_ON, ST_LATCH, ST_COOL
  } hs_state_e;

  typedef enum logic [2:0] {
    TM_CLEAR, TM_HOLD, TM_UP_SLOW, TM_UP_FAULT, TM_DN_FAST, TM_DN_RETRY
  } tmr_mode_e;
endpackage

// File: rtl/hs_en_filter.sv
module hs_en_filter #(
  parameter int unsigned FILT_CYC = 375
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_f_o
);
  generate
    if (FILT_CYC == 0) begin : g_bypass
      logic en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= en_i;
      end
      assign en_f_o = en_q;
    end else begin : g_filt
      localparam int unsigned FW = $clog2(FILT_CYC + 1);
      localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);
      logic [FW-1:0] cnt_q;
      logic          en_q;
      // rising passes at once, falling needs FILT_CYC consecutive low samples
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          en_q  <= 1'b0;
          cnt_q <= '0;
        end else if (en_i) begin
          en_q  <= 1'b1;
          cnt_q <= '0;
        end else if (en_q) begin
          if (cnt_q == LAST) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
      assign en_f_o = en_q;
    end
  endgenerate
endmodule

// File: rtl/hs_timer.sv
module hs_timer
  import hs_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned HI       = 600,
  parameter int unsigned LO       = 100,
  parameter int unsigned UP_SLOW  = 1,
  parameter int unsigned UP_FAULT = 12,
  parameter int unsigned DN_FAST  = 20,
  parameter int unsigned RET_NUM  = 2,
  parameter int unsigned RET_DEN  = 5
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  tmr_mode_e mode_i,
  output logic      at_hi_o,
  output logic      at_lo_o
);
  localparam logic [CNT_W-1:0] HI_C  = CNT_W'(HI);
  localparam logic [CNT_W-1:0] LO_C  = CNT_W'(LO);
  localparam logic [CNT_W-1:0] DNF_C = CNT_W'(DN_FAST);
  localparam logic [CNT_W:0]   HI_X  = (CNT_W+1)'(HI);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum_slow, sum_fault;
  logic             ret_step;

  generate
    if (RET_DEN <= 1) begin : g_whole
      assign ret_step = 1'b1;
    end else begin : g_frac
      localparam int unsigned AW = $clog2(RET_DEN + RET_NUM + 1);
      logic [AW-1:0] acc_q, acc_sum;
      assign acc_sum  = acc_q + AW'(RET_NUM);
      assign ret_step = (acc_sum >= AW'(RET_DEN));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     acc_q <= '0;
        else if (mode_i != TM_DN_RETRY)  acc_q <= '0;
        else if (ret_step)               acc_q <= acc_sum - AW'(RET_DEN);
        else                             acc_q <= acc_sum;
      end
    end
  endgenerate

  assign sum_slow  = {1'b0, cnt_q} + (CNT_W+1)'(UP_SLOW);
  assign sum_fault = {1'b0, cnt_q} + (CNT_W+1)'(UP_FAULT);

  always_comb begin
    cnt_d = cnt_q;
    unique case (mode_i)
      TM_CLEAR:    cnt_d = '0;
      TM_HOLD:     cnt_d = cnt_q;
      TM_UP_SLOW:  cnt_d = (sum_slow  >= HI_X) ? HI_C : sum_slow[CNT_W-1:0];
      TM_UP_FAULT: cnt_d = (sum_fault >= HI_X) ? HI_C : sum_fault[CNT_W-1:0];
      TM_DN_FAST:  cnt_d = (cnt_q > DNF_C) ? cnt_q - DNF_C : '0;
      TM_DN_RETRY: cnt_d = (ret_step && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
      default:     cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign at_hi_o = (cnt_q >= HI_C);
  assign at_lo_o = (cnt_q <= LO_C);
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
  import hs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      supply_ok_i,
  input  logic      en_f_i,
  input  logic      sw_off_i,
  input  logic      retry_mode_i,
  input  logic      oc_timed_i,
  input  logic      at_hi_i,
  input  logic      at_lo_i,
  output hs_state_e state_o,
  output tmr_mode_e mode_o,
  output logic      fault_pulse_o
);
  hs_state_e st_q, st_d;
  logic      pulse_q;
  logic      off_req;

  assign off_req = !en_f_i || sw_off_i;

  always_comb begin
    st_d   = st_q;
    mode_o = TM_HOLD;
    if (!supply_ok_i) begin
      st_d   = ST_LOCK;
      mode_o = TM_CLEAR;
    end else begin
      unique case (st_q)
        ST_LOCK: begin
          st_d   = ST_INIT_UP;
          mode_o = TM_CLEAR;
        end
        ST_INIT_UP: begin
          if (at_hi_i) st_d = ST_INIT_DN;
          else         mode_o = TM_UP_SLOW;
        end
        ST_INIT_DN: begin
          mode_o = TM_DN_FAST;
          if (at_lo_i) st_d = ST_IDLE;
        end
        ST_IDLE: begin
          mode_o = TM_DN_FAST;
          if (!off_req) st_d = ST_ON;
        end
        ST_ON: begin
          if (off_req) begin
            st_d   = ST_IDLE;
            mode_o = TM_DN_FAST;
          end else if (oc_timed_i) begin
            if (at_hi_i) st_d = retry_mode_i ? ST_COOL : ST_LATCH;
            else         mode_o = TM_UP_FAULT;
          end else begin
            mode_o = TM_DN_FAST;
          end
        end
        ST_LATCH: begin
          mode_o = TM_DN_FAST;
          if (!en_f_i) st_d = ST_IDLE;
        end
        ST_COOL: begin
          if (off_req) begin
            st_d   = ST_IDLE;
            mode_o = TM_DN_FAST;
          end else if (at_lo_i) begin
            st_d = ST_ON;
          end else begin
            mode_o = TM_DN_RETRY;
          end
        end
        default: begin
          st_d   = ST_LOCK;
          mode_o = TM_CLEAR;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_LOCK;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= (st_d == ST_LATCH || st_d == ST_COOL) &&
                 !(st_q == ST_LATCH || st_q == ST_COOL);
    end
  end

  assign state_o       = st_q;
  assign fault_pulse_o = pulse_q;
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq
  import hs_pkg::*;
#(
  parameter int unsigned TMR_HI        = 600,
  parameter int unsigned TMR_LO        = 100,
  parameter int unsigned RATE_INIT_UP  = 1,
  parameter int unsigned RATE_FAULT_UP = 12,
  parameter int unsigned RATE_FAST_DN  = 20,
  parameter int unsigned RETRY_NUM     = 2,
  parameter int unsigned RETRY_DEN     = 5,
  parameter int unsigned EN_FILT_CYC   = 375
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic en_i,
  input  logic sw_off_i,
  input  logic retry_mode_i,
  input  logic oc_timed_i,
  input  logic oc_fast_i,
  output logic gate_on_o,
  output logic gate_fast_pd_o,
  output logic fault_o,
  output logic fault_pulse_o,
  output logic ready_o,
  output logic timing_o
);
  localparam int unsigned TMR_W = $clog2(TMR_HI + 1);

  logic      en_f, at_hi, at_lo;
  hs_state_e st;
  tmr_mode_e tmode;
  logic      st_on, st_fault;

  hs_en_filter #(.FILT_CYC(EN_FILT_CYC)) u_en_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .en_f_o (en_f)
  );

  hs_timer #(
    .CNT_W   (TMR_W),
    .HI      (TMR_HI),
    .LO      (TMR_LO),
    .UP_SLOW (RATE_INIT_UP),
    .UP_FAULT(RATE_FAULT_UP),
    .DN_FAST (RATE_FAST_DN),
    .RET_NUM (RETRY_NUM),
    .RET_DEN (RETRY_DEN)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (tmode),
    .at_hi_o (at_hi),
    .at_lo_o (at_lo)
  );

  hs_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .supply_ok_i   (supply_ok_i),
    .en_f_i        (en_f),
    .sw_off_i      (sw_off_i),
    .retry_mode_i  (retry_mode_i),
    .oc_timed_i    (oc_timed_i),
    .at_hi_i       (at_hi),
    .at_lo_i       (at_lo),
    .state_o       (st),
    .mode_o        (tmode),
    .fault_pulse_o (fault_pulse_o)
  );

  assign st_on    = (st == ST_ON);
  assign st_fault = (st == ST_LATCH) || (st == ST_COOL);

  // fast trip acts on the gate directly, bypassing timer and state
  assign gate_on_o      = st_on && !oc_fast_i;
  assign gate_fast_pd_o = (st_on && oc_fast_i) || st_fault;
  assign fault_o        = st_fault;
  assign ready_o        = st_on || st_fault || (st == ST_IDLE);
  assign timing_o       = st_on && oc_timed_i;
endmodule

// File: rtl/hs_checker.sv
module hs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic sw_off_i,
  input logic oc_fast_i,
  input logic gate_on_o,
  input logic gate_fast_pd_o,
  input logic fault_o,
  input logic fault_pulse_o,
  input logic ready_o
);
  assert_lockout_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!gate_on_o && !ready_o && !fault_o));

  assert_gate_needs_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_on_o |-> ready_o);

  assert_fault_gate_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!gate_on_o && gate_fast_pd_o));

  assert_fast_trip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_fast_i |-> !gate_on_o);

  assert_gate_drive_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_on_o && gate_fast_pd_o));

  assert_sw_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_off_i |=> !gate_on_o);

  assert_pulse_in_fault_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pulse_o |-> fault_o);

  assert_pulse_on_entry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> fault_pulse_o);

  assert_pulse_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_pulse_o |=> !fault_pulse_o);
endmodule

bind hotswap_seq hs_checker u_chk (.*);

// File: tb/hotswap_seq_tb.sv
module hotswap_seq_tb;
  localparam int HI = 600, LO = 100, UPS = 1, UPF = 12, DNF = 20;
  localparam int RNUM = 2, RDEN = 5, FILT = 375;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 1'b0, en = 1'b0, sw_off = 1'b0, retry = 1'b0;
  logic oc_t = 1'b0, oc_f = 1'b0;
  logic gate_on, gate_pd, fault, fpulse, ready, timing;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  hotswap_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .en_i(en),
    .sw_off_i(sw_off), .retry_mode_i(retry), .oc_timed_i(oc_t), .oc_fast_i(oc_f),
    .gate_on_o(gate_on), .gate_fast_pd_o(gate_pd), .fault_o(fault),
    .fault_pulse_o(fpulse), .ready_o(ready), .timing_o(timing)
  );

  // behavioural reference: 0 lock,1 init up,2 init down,3 idle,4 on,5 latched,6 cooling
  int m_st = 0, m_t = 0, m_acc = 0, m_fc = 0;
  bit m_en = 0, m_pulse = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_acc = 0; m_fc = 0; m_en = 0; m_pulse = 0;
    end else begin
      int ns, md;
      bit off;
      ns = m_st; md = 1;  // 0 clr,1 hold,2 slow up,3 fault up,4 fast dn,5 retry dn
      off = !m_en || sw_off;
      if (!supply_ok) begin ns = 0; md = 0; end
      else if (m_st == 0) begin ns = 1; md = 0; end
      else if (m_st == 1) begin if (m_t >= HI) ns = 2; else md = 2; end
      else if (m_st == 2) begin md = 4; if (m_t <= LO) ns = 3; end
      else if (m_st == 3) begin md = 4; if (!off) ns = 4; end
      else if (m_st == 4) begin
        if (off) begin ns = 3; md = 4; end
        else if (oc_t) begin if (m_t >= HI) ns = retry ? 6 : 5; else md = 3; end
        else md = 4;
      end
      else if (m_st == 5) begin md = 4; if (!m_en) ns = 3; end
      else begin
        if (off) begin ns = 3; md = 4; end
        else if (m_t <= LO) ns = 4;
        else md = 5;
      end
      m_pulse = (ns == 5 || ns == 6) && !(m_st == 5 || m_st == 6);
      case (md)
        0: m_t = 0;
        2: m_t = (m_t + UPS > HI) ? HI : m_t + UPS;
        3: m_t = (m_t + UPF > HI) ? HI : m_t + UPF;
        4: m_t = (m_t > DNF) ? m_t - DNF : 0;
        5: begin
          m_acc += RNUM;
          if (m_acc >= RDEN) begin m_acc -= RDEN; if (m_t > 0) m_t--; end
        end
        default: ;
      endcase
      if (md != 5) m_acc = 0;
      if (en) begin m_en = 1; m_fc = 0; end
      else if (m_en) begin
        if (m_fc == FILT - 1) begin m_en = 0; m_fc = 0; end else m_fc++;
      end
      m_st = ns;
    end
  end

  task automatic check_one(string name, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", cur_req, name, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit on, flt;
    on  = (m_st == 4);
    flt = (m_st == 5 || m_st == 6);
    check_one("gate_on",  gate_on, on && !oc_f);
    check_one("gate_pd",  gate_pd, (on && oc_f) || flt);
    check_one("fault",    fault,   flt);
    check_one("pulse",    fpulse,  m_pulse);
    check_one("ready",    ready,   m_st >= 3);
    check_one("timing",   timing,  on && oc_t);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    // R1: reset state and lockout with enable already high
    @(negedge clk);
    compare();
    rst_n = 1'b1; en = 1'b1;
    run(20);
    // R2, R3: two-phase power-on delay, then start with enable high
    cur_req = "R2"; supply_ok = 1'b1;
    run(640);
    cur_req = "R3";
    run(10);
    // R4: short timed overcurrent, then clears; gate stays on
    cur_req = "R4"; oc_t = 1'b1; run(30); oc_t = 1'b0; run(40);
    // R8: fast trip pulse while on
    cur_req = "R8"; oc_f = 1'b1; run(3); oc_f = 1'b0; run(5);
    // R5, R11, R6: latch mode fault, overcurrent released, still latched
    cur_req = "R5"; retry = 1'b0; oc_t = 1'b1; run(60);
    cur_req = "R6"; oc_t = 1'b0; oc_f = 1'b1; run(20); oc_f = 1'b0; run(20);
    en = 1'b0; run(400);
    en = 1'b1; run(10);
    // R9: software off, then release
    cur_req = "R9"; sw_off = 1'b1; run(5); sw_off = 1'b0; run(10);
    // R10: enable glitch shorter than filter, then a real release
    cur_req = "R10"; en = 1'b0; run(100); en = 1'b1; run(10);
    en = 1'b0; run(380);
    cur_req = "R9"; run(10); en = 1'b1; run(10);
    // R7, R11: retry mode with persistent overcurrent
    cur_req = "R7"; retry = 1'b1; oc_t = 1'b1; run(3000);
    oc_t = 1'b0; run(1400);
    // R1: supply loss while on
    cur_req = "R1"; supply_ok = 1'b0; run(10);
    supply_ok = 1'b1; run(50);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule